// File: doc/BRIEF.md
# Ethernet MAC Descriptor Ring Controller

This block holds the transmit and receive descriptor rings of a small Ethernet MAC and decides which buffer the frame engines use next. Each direction has four slots. A slot has an address register (a 2 KB aligned buffer base whose low bits carry control flags), a status register and, on the transmit side, a length register. Software reaches all of them over a plain 32-bit register port with a combinational read path.

Software hands a slot to hardware by writing the buffer base with the enable flag set. Hardware walks the slots in strict index order and wraps after the last one. When it finishes a slot it writes the status word and sets a done flag in the same cycle. Software acknowledges the slot by writing zero to its address register. Every address register also reports the index of the slot that hardware will use next, so software can line up its own ring pointers after reset.

The transmit side launches a frame with a one-cycle start pulse and then waits for a completion handshake that carries the abort and collision results. The receive side takes a frame report (length including CRC, plus an error vector) and stores it in the current slot if that slot is ready. If the slot is not ready, the frame is dropped and the drop is flagged in the status of the next stored frame.

Top module: `eth_desc_ring`

## Requirements
- R1: Transmit and receive each keep a current-slot index that starts at 0, moves to the next slot only when that direction finishes a slot, and wraps from slot 3 back to slot 0.
- R2: A register word address is {dir, slot[1:0], sel[1:0]}, where dir=0 means transmit and dir=1 means receive, and sel=0 is status, sel=1 is address and sel=2 is transmit length. An address register reads buffer base in bits [31:11], enable in bit 0 and done in bit 1. A write stores bits [31:11] and bit 0, ignores bits [10:1] and clears done, so writing zero acknowledges the slot.
- R3: Bits [3:2] of every address register of a direction read that direction's current-slot index.
- R4: After reset every slot is disabled and not done, all status and length registers are zero, both indices are 0, and the transmit side is idle.
- R5: The transmit side raises txStart for one cycle, with txBufAddr and txLen of the current slot, only when it is idle and the current slot is enabled and not done. It holds txBusy until completion and stalls on a slot that is not ready, even when later slots are ready.
- R6: On txComplete while busy, the current transmit status becomes bit 0 aborted, bit 1 excessive collisions, [7:4] collision count, and [12:8] total attempts (16 when excessive, else the count). Done is set in the same cycle.
- R7: A received frame that finds the current receive slot enabled and not done is stored as length (CRC included) in [13:0] and error inputs 0..8 in bits [25:17]. The error inputs are, in order, unknown control, length error, CRC error, medium error, late collision, too long, runt, watchdog and dribbling bit. Done is set in the same cycle.
- R8: A received frame that finds the current slot not ready changes no slot and no index. Bit 16 (missed) of the next stored frame is then set, and cleared again for frames after it.
- R9: Receive status bit 31 (frame bad) is set when any error input other than dribbling bit is set, or when dribbling bit is set without late collision, runt or CRC error. The missed bit never sets it.
- R10: txComplete while the transmit side is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Register word address {dir, slot, sel} |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| txStart | output | 1 | One-cycle launch of the current transmit slot |
| txBusy | output | 1 | Transmit slot in flight |
| txBufAddr | output | 32 | Buffer address of the current transmit slot |
| txLen | output | 14 | Length of the current transmit slot |
| txComplete | input | 1 | Transmit completion strobe |
| txAborted | input | 1 | Completed frame was aborted |
| txExcessCol | input | 1 | Completed frame hit excessive collisions |
| txColCount | input | 4 | Collision count of the completed frame |
| rxFrameValid | input | 1 | One-cycle received-frame report |
| rxFrameLen | input | 14 | Received length including CRC |
| rxErrIn | input | 9 | Received error flags (order in R7) |
| rxSlotReady | output | 1 | Current receive slot is enabled and not done |
| rxBufAddr | output | 32 | Buffer address of the current receive slot |

## Verification
The assertions assume that rxFrameValid and txComplete are single-cycle pulses, that txComplete arrives only after txBusy has been seen, and that software never writes the address register of the slot that hardware finishes in that same cycle. The stimulus drives every input on the falling edge and issues one register write or one handshake at a time. It waits for txBusy before it drives a completion, and it acknowledges slots only when no completion is pending. The single idle completion pulse is an intentional exception, sent to check that it is ignored.

// File: rtl/eth_ring_pkg.sv
package eth_ring_pkg;
  localparam int DATA_W          = 32;
  localparam int LEN_W           = 14;
  localparam int COL_W           = 4;
  localparam int RX_ERR_W        = 9;
  localparam int EXCESS_ATTEMPTS = 16;

  // register select codes inside a slot
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_LEN  = 2'd2;

  // transmit status fields
  localparam int TX_ABORT_BIT  = 0;
  localparam int TX_EXCESS_BIT = 1;
  localparam int TX_CNT_LSB    = 4;
  localparam int TX_TOTAL_LSB  = 8;

  // receive status fields
  localparam int RX_MISS_BIT = 16;
  localparam int RX_ERR_LSB  = 17;
  localparam int RX_BAD_BIT  = 31;

  // receive error input positions
  localparam int ERR_CTRL_UNK = 0;
  localparam int ERR_LEN      = 1;
  localparam int ERR_CRC      = 2;
  localparam int ERR_MEDIUM   = 3;
  localparam int ERR_LATE_COL = 4;
  localparam int ERR_TOO_LONG = 5;
  localparam int ERR_RUNT     = 6;
  localparam int ERR_WDOG     = 7;
  localparam int ERR_DRIBBLE  = 8;

  typedef struct packed {
    logic txLaunch;
    logic txLoad;
    logic rxLoad;
    logic rxDrop;
  } ringStrobe_t;
endpackage

// File: rtl/eth_ring_ctrl.sv
module eth_ring_ctrl
  import eth_ring_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txSlotReady,
  input  logic              rxSlotReady,
  input  logic              txComplete,
  input  logic              rxFrameValid,
  output ringStrobe_t       strobe,
  output logic [SLOT_W-1:0] txCur,
  output logic [SLOT_W-1:0] rxCur,
  output logic              txBusy,
  output logic              missPending
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  function automatic logic [SLOT_W-1:0] nextSlot(input logic [SLOT_W-1:0] idx);
    return (idx == LAST_SLOT) ? '0 : idx + 1'b1;
  endfunction

  always_comb begin
    strobe.txLaunch = !txBusy && txSlotReady;
    strobe.txLoad   = txBusy && txComplete;
    strobe.rxLoad   = rxFrameValid && rxSlotReady;
    strobe.rxDrop   = rxFrameValid && !rxSlotReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCur       <= '0;
      rxCur       <= '0;
      txBusy      <= 1'b0;
      missPending <= 1'b0;
    end else begin
      if (strobe.txLaunch) begin
        txBusy <= 1'b1;
      end else if (strobe.txLoad) begin
        txBusy <= 1'b0;
        txCur  <= nextSlot(txCur);
      end
      if (strobe.rxLoad) begin
        rxCur       <= nextSlot(rxCur);
        missPending <= 1'b0;
      end else if (strobe.rxDrop) begin
        missPending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eth_ring_regs.sv
module eth_ring_regs
  import eth_ring_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int ALIGN_BITS = 11,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int RA_W   = SLOT_W + 3,
  localparam int BASE_W = DATA_W - ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RA_W-1:0]   regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  ringStrobe_t       strobe,
  input  logic [SLOT_W-1:0] txCur,
  input  logic [SLOT_W-1:0] rxCur,
  input  logic              missPending,
  input  logic              txAborted,
  input  logic              txExcessCol,
  input  logic [COL_W-1:0]  txColCount,
  input  logic [LEN_W-1:0]  rxFrameLen,
  input  logic [RX_ERR_W-1:0] rxErrIn,
  output logic              txSlotReady,
  output logic              rxSlotReady,
  output logic [DATA_W-1:0] txBufAddr,
  output logic [LEN_W-1:0]  txLen,
  output logic [DATA_W-1:0] rxBufAddr
);
  logic [BASE_W-1:0] txBase [NUM_SLOTS];
  logic [BASE_W-1:0] rxBase [NUM_SLOTS];
  logic [DATA_W-1:0] txStat [NUM_SLOTS];
  logic [DATA_W-1:0] rxStat [NUM_SLOTS];
  logic [LEN_W-1:0]  txLenR [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] txEn, txDn, rxEn, rxDn;

  logic              wrRx;
  logic [SLOT_W-1:0] wrSlot;
  logic [1:0]        wrSel;
  logic [DATA_W-1:0] txStatNew, rxStatNew;
  logic              rxBad;

  assign wrRx   = regAddr[RA_W-1];
  assign wrSlot = regAddr[2 +: SLOT_W];
  assign wrSel  = regAddr[1:0];

  function automatic logic [DATA_W-1:0] addrWord(input logic [BASE_W-1:0] b,
                                                 input logic e, input logic d,
                                                 input logic [SLOT_W-1:0] c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DATA_W-1:ALIGN_BITS] = b;
    w[2 +: SLOT_W] = c;
    w[1] = d;
    w[0] = e;
    return w;
  endfunction

  // status words built from the frame-side handshakes
  always_comb begin
    txStatNew = '0;
    txStatNew[TX_ABORT_BIT]          = txAborted;
    txStatNew[TX_EXCESS_BIT]         = txExcessCol;
    txStatNew[TX_CNT_LSB +: COL_W]   = txColCount;
    txStatNew[TX_TOTAL_LSB +: COL_W+1] = txExcessCol ? (COL_W+1)'(EXCESS_ATTEMPTS)
                                                     : {1'b0, txColCount};
  end

  always_comb begin
    rxBad = (|rxErrIn[ERR_DRIBBLE-1:0]) ||
            (rxErrIn[ERR_DRIBBLE] &&
             !(rxErrIn[ERR_LATE_COL] || rxErrIn[ERR_RUNT] || rxErrIn[ERR_CRC]));
    rxStatNew = '0;
    rxStatNew[LEN_W-1:0]                = rxFrameLen;
    rxStatNew[RX_MISS_BIT]              = missPending;
    rxStatNew[RX_ERR_LSB +: RX_ERR_W]   = rxErrIn;
    rxStatNew[RX_BAD_BIT]               = rxBad;
  end

  // slot storage: software writes first, hardware updates take precedence
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEn <= '0; txDn <= '0; rxEn <= '0; rxDn <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        txBase[i] <= '0; rxBase[i] <= '0;
        txStat[i] <= '0; rxStat[i] <= '0;
        txLenR[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (regWrEn && wrSlot == SLOT_W'(i)) begin
          if (!wrRx) begin
            case (wrSel)
              SEL_STAT: txStat[i] <= regWrData;
              SEL_ADDR: begin
                txBase[i] <= regWrData[DATA_W-1:ALIGN_BITS];
                txEn[i]   <= regWrData[0];
                txDn[i]   <= 1'b0;
              end
              SEL_LEN:  txLenR[i] <= regWrData[LEN_W-1:0];
              default:  ;
            endcase
          end else begin
            case (wrSel)
              SEL_STAT: rxStat[i] <= regWrData;
              SEL_ADDR: begin
                rxBase[i] <= regWrData[DATA_W-1:ALIGN_BITS];
                rxEn[i]   <= regWrData[0];
                rxDn[i]   <= 1'b0;
              end
              default:  ;
            endcase
          end
        end
        if (strobe.txLoad && txCur == SLOT_W'(i)) begin
          txStat[i] <= txStatNew;
          txDn[i]   <= 1'b1;
        end
        if (strobe.rxLoad && rxCur == SLOT_W'(i)) begin
          rxStat[i] <= rxStatNew;
          rxDn[i]   <= 1'b1;
        end
      end
    end
  end

  // combinational read path
  always_comb begin
    regRdData = '0;
    case (wrSel)
      SEL_STAT: regRdData = wrRx ? rxStat[wrSlot] : txStat[wrSlot];
      SEL_ADDR: regRdData = wrRx ? addrWord(rxBase[wrSlot], rxEn[wrSlot], rxDn[wrSlot], rxCur)
                                 : addrWord(txBase[wrSlot], txEn[wrSlot], txDn[wrSlot], txCur);
      SEL_LEN:  regRdData = wrRx ? '0 : DATA_W'(txLenR[wrSlot]);
      default:  regRdData = '0;
    endcase
  end

  assign txSlotReady = txEn[txCur] && !txDn[txCur];
  assign rxSlotReady = rxEn[rxCur] && !rxDn[rxCur];
  assign txBufAddr   = {txBase[txCur], {ALIGN_BITS{1'b0}}};
  assign rxBufAddr   = {rxBase[rxCur], {ALIGN_BITS{1'b0}}};
  assign txLen       = txLenR[txCur];
endmodule

// File: rtl/eth_desc_ring.sv
module eth_desc_ring
  import eth_ring_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int ALIGN_BITS = 11
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [$clog2(NUM_SLOTS)+2:0] regAddr,
  input  logic                        regWrEn,
  input  logic [31:0]                 regWrData,
  output logic [31:0]                 regRdData,
  output logic                        txStart,
  output logic                        txBusy,
  output logic [31:0]                 txBufAddr,
  output logic [13:0]                 txLen,
  input  logic                        txComplete,
  input  logic                        txAborted,
  input  logic                        txExcessCol,
  input  logic [3:0]                  txColCount,
  input  logic                        rxFrameValid,
  input  logic [13:0]                 rxFrameLen,
  input  logic [8:0]                  rxErrIn,
  output logic                        rxSlotReady,
  output logic [31:0]                 rxBufAddr
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  ringStrobe_t       strobe;
  logic [SLOT_W-1:0] txCurIdx, rxCurIdx;
  logic              missPending;
  logic              txSlotReady;

  eth_ring_ctrl #(.NUM_SLOTS(NUM_SLOTS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .txSlotReady(txSlotReady), .rxSlotReady(rxSlotReady),
    .txComplete(txComplete), .rxFrameValid(rxFrameValid),
    .strobe(strobe), .txCur(txCurIdx), .rxCur(rxCurIdx),
    .txBusy(txBusy), .missPending(missPending)
  );

  eth_ring_regs #(.NUM_SLOTS(NUM_SLOTS), .ALIGN_BITS(ALIGN_BITS)) regs_i (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .txCur(txCurIdx), .rxCur(rxCurIdx), .missPending(missPending),
    .txAborted(txAborted), .txExcessCol(txExcessCol), .txColCount(txColCount),
    .rxFrameLen(rxFrameLen), .rxErrIn(rxErrIn),
    .txSlotReady(txSlotReady), .rxSlotReady(rxSlotReady),
    .txBufAddr(txBufAddr), .txLen(txLen), .rxBufAddr(rxBufAddr)
  );

  assign txStart = strobe.txLaunch;
endmodule

// File: rtl/eth_ring_checker.sv
module eth_ring_checker #(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              txStart,
  input logic              txBusy,
  input logic              txComplete,
  input logic              rxFrameValid,
  input logic              rxSlotReady,
  input logic [SLOT_W-1:0] txCur,
  input logic [SLOT_W-1:0] rxCur
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  // R5: a launch is followed by a busy transmit side
  assert_launch_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> txBusy);

  // R5: no second launch while a slot is in flight
  assert_single_flight_R5: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> !txStart);

  // R1: transmit index steps by one with wrap on completion
  assert_tx_advance_R1: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && txComplete) |=>
      txCur == (($past(txCur) == LAST_SLOT) ? '0 : $past(txCur) + 1'b1));

  // R10: without a busy completion the transmit index holds
  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(txBusy && txComplete) |=> $stable(txCur));

  // R1: receive index steps by one with wrap on a stored frame
  assert_rx_advance_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rxFrameValid && rxSlotReady) |=>
      rxCur == (($past(rxCur) == LAST_SLOT) ? '0 : $past(rxCur) + 1'b1));

  // R8: a dropped frame leaves the receive index where it was
  assert_rx_drop_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(rxFrameValid && rxSlotReady) |=> $stable(rxCur));
endmodule

bind eth_desc_ring eth_ring_checker #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk(clk), .rstN(rstN), .txStart(txStart), .txBusy(txBusy),
  .txComplete(txComplete), .rxFrameValid(rxFrameValid), .rxSlotReady(rxSlotReady),
  .txCur(txCurIdx), .rxCur(rxCurIdx)
);

// File: tb/eth_desc_ring_tb_top.sv
module eth_desc_ring_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData, regRdData;
  logic        txStart, txBusy, txComplete, txAborted, txExcessCol;
  logic [31:0] txBufAddr, rxBufAddr;
  logic [13:0] txLen, rxFrameLen;
  logic [3:0]  txColCount;
  logic        rxFrameValid, rxSlotReady;
  logic [8:0]  rxErrIn;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  eth_desc_ring dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .txStart(txStart), .txBusy(txBusy), .txBufAddr(txBufAddr), .txLen(txLen),
    .txComplete(txComplete), .txAborted(txAborted), .txExcessCol(txExcessCol),
    .txColCount(txColCount), .rxFrameValid(rxFrameValid), .rxFrameLen(rxFrameLen),
    .rxErrIn(rxErrIn), .rxSlotReady(rxSlotReady), .rxBufAddr(rxBufAddr)
  );

  function automatic logic [4:0] txA(input int s, input int sel);
    return {1'b0, 2'(s), 2'(sel)};
  endfunction
  function automatic logic [4:0] rxA(input int s, input int sel);
    return {1'b1, 2'(s), 2'(sel)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic completeTx(input logic ab, input logic ex, input logic [3:0] cc);
    txComplete = 1'b1; txAborted = ab; txExcessCol = ex; txColCount = cc;
    @(negedge clk);
    txComplete = 1'b0; txAborted = 1'b0; txExcessCol = 1'b0; txColCount = '0;
  endtask

  task automatic sendFrame(input logic [13:0] len, input logic [8:0] err);
    @(negedge clk);
    rxFrameValid = 1'b1; rxFrameLen = len; rxErrIn = err;
    @(negedge clk);
    rxFrameValid = 1'b0; rxFrameLen = '0; rxErrIn = '0;
  endtask

  // one full transmit slot: program, launch, complete, inspect, acknowledge
  task automatic runTxSlot(input int s, input logic [31:0] base, input logic [13:0] len,
                           input logic ab, input logic ex, input logic [3:0] cc,
                           input logic [31:0] expStat);
    logic [31:0] d;
    writeReg(txA(s, 2), 32'(len));
    writeReg(txA(s, 1), base | 32'h1);
    check("R5 txStart on enabled slot", 32'(txStart), 32'h1);
    check("R5 txBufAddr of current slot", txBufAddr, base);
    check("R5 txLen of current slot", 32'(txLen), 32'(len));
    @(negedge clk);
    check("R5 busy after launch, single pulse", {txBusy, txStart}, 32'h2);
    completeTx(ab, ex, cc);
    readReg(txA(s, 0), d);
    check("R6 tx status word", d, expStat);
    readReg(txA(s, 1), d);
    check("R6 done flag with status, R3 index advanced",
          d, base | 32'h3 | (32'((s + 1) % 4) << 2));
    writeReg(txA(s, 1), 32'h0);
    readReg(txA(s, 1), d);
    check("R2 zero write acknowledges", d, 32'((s + 1) % 4) << 2);
  endtask

  task automatic testReset();
    logic [31:0] d;
    readReg(txA(0, 1), d); check("R4 tx address reset", d, 32'h0);
    readReg(rxA(3, 1), d); check("R4 rx address reset", d, 32'h0);
    readReg(txA(2, 0), d); check("R4 tx status reset", d, 32'h0);
    check("R4 tx idle", {txStart, txBusy, rxSlotReady}, 32'h0);
  endtask

  task automatic testAddrFormat();
    logic [31:0] d;
    writeReg(txA(1, 1), 32'h0001_28FF);
    readReg(txA(1, 1), d);
    check("R2 reserved bits ignored, done not writable", d, 32'h0001_2801);
    repeat (4) @(negedge clk);
    check("R5 stall on disabled current slot", {txStart, txBusy}, 32'h0);
    writeReg(txA(1, 1), 32'h0);
  endtask

  task automatic testTxRing();
    runTxSlot(0, 32'h0000_0800, 14'd60, 1'b0, 1'b0, 4'd3, 32'h0000_0330);
    runTxSlot(1, 32'h0000_1000, 14'd100, 1'b1, 1'b1, 4'd15, 32'h0000_10F3);
    runTxSlot(2, 32'h0000_1800, 14'd200, 1'b0, 1'b0, 4'd0, 32'h0000_0000);
    runTxSlot(3, 32'h0000_2000, 14'd64, 1'b0, 1'b0, 4'd9, 32'h0000_0990);
    // R1 wrap: slot 3 finished, ring is back at slot 0 (checked inside as index 0)
    runTxSlot(0, 32'h0000_2800, 14'd1514, 1'b1, 1'b0, 4'd1, 32'h0000_0111);
  endtask

  task automatic testIdleComplete();
    logic [31:0] d;
    completeTx(1'b1, 1'b1, 4'd7);
    readReg(txA(1, 0), d);
    check("R10 idle completion leaves status", d, 32'h0000_10F3);
    readReg(txA(1, 1), d);
    check("R10 idle completion leaves index and done", d, 32'h0000_0004);
    check("R10 still idle", {txStart, txBusy}, 32'h0);
  endtask

  task automatic testTxOrder();
    logic [31:0] d;
    writeReg(txA(2, 1), 32'h0000_3001);
    repeat (3) @(negedge clk);
    check("R5 later ready slot not taken out of order", {txStart, txBusy}, 32'h0);
    writeReg(txA(1, 2), 32'd90);
    writeReg(txA(1, 1), 32'h0000_3801);
    check("R5 current slot launched first", txBufAddr, 32'h0000_3800);
    @(negedge clk);
    completeTx(1'b0, 1'b0, 4'd2);
    check("R1 R5 next slot launched after completion", {txStart, txBufAddr}, 64'h1_0000_3000);
    @(negedge clk);
    completeTx(1'b0, 1'b0, 4'd0);
    readReg(txA(2, 1), d);
    check("R1 index after two slots", d, 32'h0000_3003 | (32'd3 << 2));
    writeReg(txA(1, 1), 32'h0);
    writeReg(txA(2, 1), 32'h0);
  endtask

  task automatic testRx();
    logic [31:0] d;
    writeReg(rxA(0, 1), 32'h0000_4001);
    check("R7 slot ready output", {rxSlotReady, rxBufAddr}, 64'h1_0000_4000);
    sendFrame(14'd64, 9'h000);
    readReg(rxA(0, 0), d);
    check("R7 R9 clean frame status", d, 32'h0000_0040);
    readReg(rxA(0, 1), d);
    check("R7 rx done set, R3 rx index", d, 32'h0000_4007);
    sendFrame(14'd99, 9'h000);
    readReg(rxA(1, 1), d);
    check("R8 dropped frame keeps index", d, 32'h0000_0004);
    readReg(rxA(1, 0), d);
    check("R8 dropped frame writes no status", d, 32'h0);
    writeReg(rxA(1, 1), 32'h0000_4801);
    sendFrame(14'd70, 9'h104);
    readReg(rxA(1, 0), d);
    check("R8 R9 missed flag, crc with dribble", d, 32'h8209_0046);
    writeReg(rxA(2, 1), 32'h0000_5001);
    sendFrame(14'd72, 9'h100);
    readReg(rxA(2, 0), d);
    check("R9 dribble alone is an error, missed cleared", d, 32'h8200_0048);
    sendFrame(14'd33, 9'h000);
    writeReg(rxA(3, 1), 32'h0000_5801);
    sendFrame(14'd80, 9'h000);
    readReg(rxA(3, 0), d);
    check("R9 missed alone does not mark frame bad", d, 32'h0001_0050);
    readReg(rxA(3, 1), d);
    check("R1 rx index wraps to 0", d, 32'h0000_5803);
    sendFrame(14'd50, 9'h002);
    readReg(rxA(0, 0), d);
    check("R8 done slot not overwritten", d, 32'h0000_0040);
    writeReg(rxA(0, 1), 32'h0000_4001);
    sendFrame(14'd50, 9'h002);
    readReg(rxA(0, 0), d);
    check("R7 length error mapping after reuse", d, 32'h8005_0032);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    txComplete = 1'b0; txAborted = 1'b0; txExcessCol = 1'b0; txColCount = '0;
    rxFrameValid = 1'b0; rxFrameLen = '0; rxErrIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAddrFormat();
    testTxRing();
    testIdleComplete();
    testTxOrder();
    testRx();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule